// File: doc/BRIEF.md
# Ring-Timed Phase Clock Master

This block is the digital timing master for a multiphase converter built from a chain of phase slices. Every slice runs on the same system clock as this block. The block sends a one-cycle phase token into the first slice. Each slice delays the token by one system clock and passes it on. The last slice returns the token on the feedback input. After enable, the block first waits until the ring is quiet. It then sends a single probe token and counts the cycles until the token comes back. That count is the number of phases.

Once the count is known, the block sends a fresh token every N system clocks, where N is the phase count. Each slice therefore switches at the system clock rate divided by N, and the system clock runs at N times the per-phase rate. In this locked mode the block checks every cycle that the token comes back exactly when it should. It also checks that nothing appears on the feedback input at any other time. A missing token, a late token or a stray token latches an open-chain fault and drops the ready output. Only removing the enable clears the fault.

Top module: `dcp_phase_master`

## Requirements
- R1: While reset is high, and in the first cycle after reset, `tok_o`, `ready`, `fault` and `phase_cnt` are all 0.
- R2: The probe token goes out on `tok_o` only after `en` is high and `tok_i` has been low for 16 consecutive cycles. When the block has just returned to idle, `tok_o` stays low for at least the next 16 cycles.
- R3: A probe token that returns on `tok_i` K cycles after it was sent, with K from 1 to 15, gives `phase_cnt` = K. `ready` goes high in the cycle after the return, which is K+1 cycles after the probe cycle.
- R4: While `ready` is high, `tok_o` is high in the first ready cycle and in every K-th cycle after it, and low in all other cycles.
- R5: If the probe token does not return within 15 cycles, `fault` goes high 17 cycles after the probe cycle. At that point `ready` is 0 and `phase_cnt` is 0.
- R6: In locked operation, a token that is missing in its expected return cycle raises `fault` in the next cycle.
- R7: In locked operation, `tok_i` high in a cycle where `tok_o` is low raises `fault` in the next cycle. The same applies to `tok_i` high in the first ready cycle.
- R8: While `en` stays high, `fault` stays high once it is set, and `tok_o` and `ready` stay low.
- R9: `en` low for one clock edge returns the block to idle, with `ready`, `fault`, `phase_cnt` and `tok_o` all 0. Raising `en` again starts a new detection.
- R10: `ready` and `fault` are never high together. `phase_cnt` is nonzero exactly when `ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, shared with every phase slice |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Run enable; low clears a fault and returns the block to idle |
| tok_i | input | 1 | Token returned by the last slice of the ring |
| tok_o | output | 1 | Token into the first slice of the ring |
| ready | output | 1 | High while the phase count is valid and the ring is intact |
| fault | output | 1 | Open-chain fault, latched until `en` drops |
| phase_cnt | output | PH_W | Detected number of phases, 0 when not ready |

## Verification
A wrong shared counter shows up first in the return timing. A miscount during detection appears at `phase_cnt` and in the ready latency one cycle after the probe comes back. A counter that drifts in locked mode moves the spacing of `tok_o` away from N within one period. A wrong expected-return flag or compare raises `fault` one cycle after a correct return, or misses a break or a stray token for that same cycle. Either case is visible before the next token is sent.

// File: rtl/dcp_pkg.sv
package dcp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEND,
        ST_COUNT,
        ST_LOCKED,
        ST_FAULT
    } dcp_state_e;

    typedef enum logic [1:0] {
        CNT_HOLD,
        CNT_CLEAR,
        CNT_INC,
        CNT_ONE
    } cnt_op_e;

    function automatic int unsigned limit_of(input int unsigned ph_w);
        return 32'd1 << ph_w;
    endfunction

endpackage

// File: rtl/dcp_cnt.sv
module dcp_cnt
    import dcp_pkg::*;
#(
    parameter int W = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  cnt_op_e       op,
    output logic [W-1:0]  q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            case (op)
                CNT_CLEAR: q <= '0;
                CNT_INC:   q <= q + W'(1);
                CNT_ONE:   q <= W'(1);
                default:   q <= q;
            endcase
        end
    end

endmodule

// File: rtl/dcp_ring_mon.sv
module dcp_ring_mon
    import dcp_pkg::*;
#(
    parameter int PH_W = 4
) (
    input  logic [PH_W:0]   cnt,
    input  logic [PH_W-1:0] n_phases,
    input  logic            armed,
    input  logic            tok_i,
    output logic            at_limit,
    output logic            at_zero,
    output logic            at_wrap,
    output logic            mismatch
);

    localparam int CNT_W = PH_W + 1;
    localparam int LIMIT = int'(limit_of(PH_W));

    logic expect_tok;

    always_comb begin
        at_limit   = (cnt == CNT_W'(LIMIT));
        at_zero    = (cnt == '0);
        at_wrap    = (cnt == {1'b0, n_phases - PH_W'(1)});
        expect_tok = armed && at_zero;
        mismatch   = (tok_i != expect_tok);
    end

endmodule

// File: rtl/dcp_fsm.sv
module dcp_fsm
    import dcp_pkg::*;
#(
    parameter int PH_W = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            en,
    input  logic            tok_i,
    input  logic [PH_W-1:0] cnt_lo,
    input  logic            at_limit,
    input  logic            at_zero,
    input  logic            at_wrap,
    input  logic            mismatch,
    output cnt_op_e         op,
    output logic [PH_W-1:0] n_phases,
    output logic            armed,
    output logic            tok_o,
    output logic            ready,
    output logic            fault
);

    dcp_state_e      st_q, st_d;
    logic [PH_W-1:0] n_d;
    logic            armed_d;

    always_comb begin
        st_d    = st_q;
        n_d     = n_phases;
        armed_d = armed;
        op      = CNT_HOLD;
        case (st_q)
            ST_IDLE: begin
                if (tok_i) begin
                    op = CNT_CLEAR;
                end else if (at_limit) begin
                    if (en) st_d = ST_SEND;
                end else begin
                    op = CNT_INC;
                end
            end
            ST_SEND: begin
                op   = CNT_ONE;
                st_d = ST_COUNT;
            end
            ST_COUNT: begin
                if (at_limit) begin
                    st_d = ST_FAULT;
                    op   = CNT_CLEAR;
                end else if (tok_i) begin
                    st_d    = ST_LOCKED;
                    n_d     = cnt_lo;
                    armed_d = 1'b0;
                    op      = CNT_CLEAR;
                end else begin
                    op = CNT_INC;
                end
            end
            ST_LOCKED: begin
                if (mismatch) begin
                    st_d = ST_FAULT;
                    op   = CNT_CLEAR;
                end else begin
                    armed_d = 1'b1;
                    op      = at_wrap ? CNT_CLEAR : CNT_INC;
                end
            end
            ST_FAULT: op = CNT_CLEAR;
            default:  st_d = ST_IDLE;
        endcase
        if (!en && st_q != ST_IDLE) begin
            st_d    = ST_IDLE;
            op      = CNT_CLEAR;
            n_d     = '0;
            armed_d = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= ST_IDLE;
            n_phases <= '0;
            armed    <= 1'b0;
        end else begin
            st_q     <= st_d;
            n_phases <= n_d;
            armed    <= armed_d;
        end
    end

    always_comb begin
        tok_o = (st_q == ST_SEND) || (st_q == ST_LOCKED && at_zero);
        ready = (st_q == ST_LOCKED);
        fault = (st_q == ST_FAULT);
    end

endmodule

// File: rtl/dcp_phase_master.sv
module dcp_phase_master
    import dcp_pkg::*;
#(
    parameter int PH_W = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            en,
    input  logic            tok_i,
    output logic            tok_o,
    output logic            ready,
    output logic            fault,
    output logic [PH_W-1:0] phase_cnt
);

    localparam int CNT_W = PH_W + 1;

    cnt_op_e          op;
    logic [CNT_W-1:0] cnt_q;
    logic [PH_W-1:0]  n_phases;
    logic             armed;
    logic             at_limit, at_zero, at_wrap, mismatch;

    dcp_cnt #(.W(CNT_W)) u_cnt (
        .clk (clk),
        .rst (rst),
        .op  (op),
        .q   (cnt_q)
    );

    dcp_ring_mon #(.PH_W(PH_W)) u_mon (
        .cnt      (cnt_q),
        .n_phases (n_phases),
        .armed    (armed),
        .tok_i    (tok_i),
        .at_limit (at_limit),
        .at_zero  (at_zero),
        .at_wrap  (at_wrap),
        .mismatch (mismatch)
    );

    dcp_fsm #(.PH_W(PH_W)) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .tok_i    (tok_i),
        .cnt_lo   (cnt_q[PH_W-1:0]),
        .at_limit (at_limit),
        .at_zero  (at_zero),
        .at_wrap  (at_wrap),
        .mismatch (mismatch),
        .op       (op),
        .n_phases (n_phases),
        .armed    (armed),
        .tok_o    (tok_o),
        .ready    (ready),
        .fault    (fault)
    );

    assign phase_cnt = ready ? n_phases : '0;

endmodule

// File: rtl/dcp_phase_master_chk.sv
module dcp_phase_master_chk #(
    parameter int PH_W = 4
) (
    input logic            clk,
    input logic            rst,
    input logic            en,
    input logic            tok_i,
    input logic            tok_o,
    input logic            ready,
    input logic            fault,
    input logic [PH_W-1:0] phase_cnt
);

    AST_READY_FAULT_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(ready && fault)); // R10

    AST_PHASE_WHEN_READY: assert property (@(posedge clk) disable iff (rst)
        ready |-> (phase_cnt != '0)); // R10

    AST_PHASE_ZERO_IDLE: assert property (@(posedge clk) disable iff (rst)
        !ready |-> (phase_cnt == '0)); // R10

    AST_PHASE_STABLE: assert property (@(posedge clk) disable iff (rst)
        (ready && $past(ready)) |-> (phase_cnt == $past(phase_cnt))); // R3

    AST_LOCK_TOKEN: assert property (@(posedge clk) disable iff (rst)
        $rose(ready) |-> tok_o); // R4

    AST_STRAY_FAULT: assert property (@(posedge clk) disable iff (rst)
        (ready && en && tok_i && !tok_o) |=> fault); // R7

    AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (rst)
        (fault && en) |=> fault); // R8

    AST_FAULT_QUIET: assert property (@(posedge clk) disable iff (rst)
        fault |-> (!tok_o && !ready)); // R8

    AST_DISABLE_IDLE: assert property (@(posedge clk) disable iff (rst)
        !en |=> (!ready && !fault)); // R9

endmodule

bind dcp_phase_master dcp_phase_master_chk #(.PH_W(PH_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .tok_i     (tok_i),
    .tok_o     (tok_o),
    .ready     (ready),
    .fault     (fault),
    .phase_cnt (phase_cnt)
);

// File: tb/dcp_phase_master_tb.sv
module dcp_phase_master_tb;

    localparam int CLK_PERIOD = 10;
    localparam int PH_W       = 4;
    localparam int RING_MAX   = 20;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            en  = 1'b0;
    logic            tok_i;
    logic            tok_o, ready, fault;
    logic [PH_W-1:0] phase_cnt;

    logic [RING_MAX-1:0] ring;
    int  k_sel   = 1;
    bit  open_ch = 1'b0;
    bit  brk     = 1'b0;
    bit  inj     = 1'b0;
    int  checks  = 0;
    int  errors  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // phase slices: one flop per phase on the system clock
    always_ff @(posedge clk) begin
        if (rst) ring <= '0;
        else     ring <= {ring[RING_MAX-2:0], tok_o};
    end

    always_comb begin
        tok_i = ((open_ch || brk) ? 1'b0 : ring[k_sel-1]) | inj;
    end

    dcp_phase_master #(.PH_W(PH_W)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .en        (en),
        .tok_i     (tok_i),
        .tok_o     (tok_o),
        .ready     (ready),
        .fault     (fault),
        .phase_cnt (phase_cnt)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    // count negedges until ready or fault appears
    task automatic wait_outcome(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!ready && !fault && n < 80);
    endtask

    task automatic lock_ring(input int k, output int n);
        en = 1'b0;
        open_ch = 1'b0;
        brk = 1'b0;
        k_sel = k;
        repeat (40) @(negedge clk);
        en = 1'b1;
        wait_outcome(n);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        summary();
        $finish;
    end

    initial begin
        int n;
        int bad;

        // R1 reset state
        repeat (3) @(negedge clk);
        chk(!tok_o && !ready && !fault && phase_cnt == 0, "R1", {tok_o, ready, fault}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!tok_o && !ready && !fault && phase_cnt == 0, "R1", {tok_o, ready, fault}, 0);

        // R2 idle with enable low: no token ever
        bad = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (tok_o) bad++;
        end
        chk(bad == 0, "R2", bad, 0);

        // R3/R4 sweep every legal ring length
        for (int k = 1; k <= 15; k++) begin
            lock_ring(k, n);
            chk(n == k + 2 && ready, "R3", n, k + 2);
            chk(phase_cnt == PH_W'(k), "R3", int'(phase_cnt), k);
            chk(tok_o == 1'b1, "R4", int'(tok_o), 1);
            bad = 0;
            for (int i = 1; i <= 3 * k; i++) begin
                @(negedge clk);
                if (tok_o != ((i % k) == 0)) bad++;
                if (!ready || fault) bad++;
            end
            chk(bad == 0, "R4", bad, 0);
            chk(phase_cnt == PH_W'(k), "R10", int'(phase_cnt), k);
        end

        // R5 ring of 16 is too long
        lock_ring(16, n);
        chk(n == 18 && fault, "R5", n, 18);
        chk(!ready && phase_cnt == 0, "R5", int'(phase_cnt), 0);

        // R8 fault is sticky and silent
        bad = 0;
        for (int i = 0; i < 25; i++) begin
            @(negedge clk);
            if (!fault || tok_o || ready) bad++;
        end
        chk(bad == 0, "R8", bad, 0);

        // R9 disable clears the fault
        en = 1'b0;
        @(negedge clk);
        chk(!fault && !ready && !tok_o && phase_cnt == 0, "R9", {fault, ready, tok_o}, 0);

        // R5 open chain
        k_sel = 4;
        repeat (40) @(negedge clk);
        open_ch = 1'b1;
        en = 1'b1;
        wait_outcome(n);
        chk(n == 18 && fault && !ready, "R5", n, 18);
        open_ch = 1'b0;

        // R6 break in locked operation
        lock_ring(6, n);
        chk(ready && phase_cnt == 6, "R3", int'(phase_cnt), 6);
        repeat (13) @(negedge clk);
        while (!tok_o) @(negedge clk);
        brk = 1'b1;
        @(negedge clk);
        chk(fault && !ready, "R6", int'(fault), 1);
        brk = 1'b0;

        // R7 stray token between returns
        lock_ring(5, n);
        chk(ready && phase_cnt == 5, "R3", int'(phase_cnt), 5);
        repeat (11) @(negedge clk);
        while (!tok_o) @(negedge clk);
        repeat (2) @(negedge clk);
        chk(ready && !fault, "R7", int'(fault), 0);
        inj = 1'b1;
        @(negedge clk);
        inj = 1'b0;
        chk(fault && !ready, "R7", int'(fault), 1);

        // R7 stray token in the first ready cycle
        en = 1'b0;
        k_sel = 3;
        repeat (40) @(negedge clk);
        en = 1'b1;
        do @(negedge clk); while (!ready && !fault);
        inj = 1'b1;
        @(negedge clk);
        inj = 1'b0;
        chk(fault, "R7", int'(fault), 1);

        // R2/R9 quick re-enable while tokens are in flight
        lock_ring(7, n);
        chk(ready && phase_cnt == 7, "R3", int'(phase_cnt), 7);
        repeat (3) @(negedge clk);
        en = 1'b0;
        @(negedge clk);
        chk(!ready && !fault && !tok_o, "R9", int'(ready), 0);
        en = 1'b1;
        bad = 0;
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            if (tok_o) bad++;
        end
        chk(bad == 0, "R2", bad, 0);
        wait_outcome(n);
        chk(ready && phase_cnt == 7, "R9", int'(phase_cnt), 7);

        summary();
        $finish;
    end

endmodule